// File: doc/BRIEF.md
# Flash Write Protection Controller

This block sits between the command logic and the storage array of a 256K-byte flash. It decides, for the address currently presented, whether a program or erase may change that location. The decision combines four things: whether the supply is good, a power-up lockout window, two active-low protection pins, and a sticky software lock that covers the top 16 KB boot region.

It also cleans up the raw write strobe. Short glitches are rejected, and writes are inhibited while output enable is asserted. The command decoder can then act on the registered strobe and gate every array update with `allow_o`.

Protection follows a fixed priority. Power state is checked first. The chip-wide protect pin comes next and blocks every address. The boot-lock pin follows and blocks the boot region whatever the software lock holds. The software lock is considered last.

Top module: `fwp_top`

## Requirements
- R1: The boot region is every address from 0x3C000 to 0x3FFFF inclusive (address at or above 2^ADDR_W minus BOOT_BYTES). With no protection active, every address, including 0x00000 and 0x3FFFF, gives `allow_o` = 1.
- R2: A one-cycle high pulse on `sw_lock_i`, while power is good, sets the software lock from the next clock edge on. The lock blocks 0x3C000 and 0x3FFFF, while 0x3BFFF stays allowed.
- R3: Once set, the software lock cannot be cleared by further `sw_lock_i` pulses or by write strobes. Only reset or loss of power clears it.
- R4: While `tbl_ni` = 0, boot-region addresses give `allow_o` = 0 whatever the software lock holds. Addresses below the boot region are unaffected.
- R5: While `wp_ni` = 0, every address gives `allow_o` = 0, overriding `tbl_ni` and the software lock.
- R6: `allow_o` is combinational in `addr_i` and the pins. A change of address is reflected in the same cycle, with no clock edge needed.
- R7: `wr_stb_o` goes high only at the MIN_PULSE_CYC-th consecutive clock edge that samples `we_ni` = 0 with `oe_ni` = 1. Shorter pulses never raise it. It stays high while that condition holds and drops at the first edge where the condition fails.
- R8: Sampling `oe_ni` = 0 or `we_ni` = 1 at an edge forces `wr_stb_o` = 0 after that edge and restarts the pulse count.
- R9: After `pwr_good_i` rises, `allow_o` stays 0 until POR_CYC consecutive edges have sampled `pwr_good_i` = 1. While `pwr_good_i` = 0, `allow_o` is 0 at once.
- R10: An edge that samples `pwr_good_i` = 0 clears the software lock and restarts the power-on delay.
- R11: While `rst_ni` = 0, `allow_o` and `wr_stb_o` are 0, the software lock is clear, and the power-on delay restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Address targeted by the program or erase |
| we_ni | input | 1 | Raw write strobe, active low |
| oe_ni | input | 1 | Output enable, active low; low inhibits writes |
| tbl_ni | input | 1 | Boot-region lock pin, active low |
| wp_ni | input | 1 | Whole-array protect pin, active low |
| pwr_good_i | input | 1 | Supply above sense level |
| sw_lock_i | input | 1 | One-cycle pulse that sets the sticky boot lock |
| allow_o | output | 1 | Address may be programmed or erased |
| wr_stb_o | output | 1 | Filtered, registered write strobe |

## Verification
`allow_o` depends combinationally on the address and the pins, so it is due in the same cycle as those inputs. It is sampled one time unit after they change.

The software lock and the power-on counter each add one register. Their effect on `allow_o` is therefore due after the edge that samples the pulse, or after the POR_CYC-th edge with power good. `wr_stb_o` is due after the MIN_PULSE_CYC-th qualifying edge.

A bench model advances its lock, delay and pulse-count state once per clock edge, from the inputs held before that edge. Outputs are always compared one time unit after the edge, against both literal values and that model.

// File: rtl/fwp_pkg.sv
package fwp_pkg;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_POWER,
    SRC_CHIP_WP,
    SRC_BOOT_PIN,
    SRC_SW_LOCK
  } prot_src_e;

  // Highest-priority reason that blocks a write; SRC_NONE means writable.
  function automatic prot_src_e pick_src(logic pwr_ok, logic wp_n, logic tbl_n,
                                         logic sw_lock, logic in_boot);
    if (!pwr_ok)                 return SRC_POWER;
    if (!wp_n)                   return SRC_CHIP_WP;
    if (in_boot && !tbl_n)       return SRC_BOOT_PIN;
    if (in_boot && sw_lock)      return SRC_SW_LOCK;
    return SRC_NONE;
  endfunction

endpackage

// File: rtl/fwp_strobe_filter.sv
module fwp_strobe_filter #(
  parameter int unsigned MIN_PULSE_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_ni,
  input  logic oe_ni,
  output logic stb_o
);
  localparam int unsigned CW = $clog2(MIN_PULSE_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(MIN_PULSE_CYC);

  logic          qual;
  logic [CW-1:0] cnt_q;
  logic          stb_q;

  assign qual = !we_ni && oe_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else if (!qual) begin
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else begin
      if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
      stb_q <= (cnt_q >= LIM - 1'b1);
    end
  end

  assign stb_o = stb_q;

  a_r8_inhibit_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_ni || we_ni) |=> !stb_o);

  a_r7_rise_needs_qual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stb_o) |-> $past(qual));

  generate
    if (MIN_PULSE_CYC >= 2) begin : g_width
      a_r7_no_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(stb_o) |-> $past(qual, 2));
    end
  endgenerate

endmodule

// File: rtl/fwp_por_timer.sv
module fwp_por_timer #(
  parameter int unsigned POR_CYC = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(POR_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(POR_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!pwr_good_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      cnt_q  <= cnt_q + 1'b1;
      done_q <= (cnt_q == LAST);
    end
  end

  assign done_o = done_q;

  a_r9_done_needs_power: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(pwr_good_i));

  a_r10_loss_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> !done_o);

endmodule

// File: rtl/fwp_lock_reg.sv
module fwp_lock_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic set_i,
  output logic lock_o
);
  logic lock_q;

  // Sticky: only reset or power loss clears it.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          lock_q <= 1'b0;
    else if (!pwr_good_i) lock_q <= 1'b0;
    else if (set_i)       lock_q <= 1'b1;
  end

  assign lock_o = lock_q;

  a_r2_pulse_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && pwr_good_i) |=> lock_o);

  a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && pwr_good_i) |=> lock_o);

  a_r10_loss_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> !lock_o);

endmodule

// File: rtl/fwp_prot_arbiter.sv
module fwp_prot_arbiter
  import fwp_pkg::*;
#(
  parameter int unsigned ADDR_W     = 18,
  parameter int unsigned BOOT_BYTES = 16384
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              pwr_ok_i,
  input  logic              wp_ni,
  input  logic              tbl_ni,
  input  logic              sw_lock_i,
  output logic              allow_o
);
  localparam logic [ADDR_W-1:0] BOOT_BASE = ADDR_W'((2 ** ADDR_W) - BOOT_BYTES);

  logic      in_boot;
  prot_src_e src;

  assign in_boot = (addr_i >= BOOT_BASE);
  assign src     = pick_src(pwr_ok_i, wp_ni, tbl_ni, sw_lock_i, in_boot);
  assign allow_o = (src == SRC_NONE);

endmodule

// File: rtl/fwp_top.sv
module fwp_top #(
  parameter int unsigned ADDR_W        = 18,
  parameter int unsigned BOOT_BYTES    = 16384,
  parameter int unsigned MIN_PULSE_CYC = 2,
  parameter int unsigned POR_CYC       = 500000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic              tbl_ni,
  input  logic              wp_ni,
  input  logic              pwr_good_i,
  input  logic              sw_lock_i,
  output logic              allow_o,
  output logic              wr_stb_o
);
  localparam logic [ADDR_W-1:0] BOOT_BASE = ADDR_W'((2 ** ADDR_W) - BOOT_BYTES);

  logic por_done;
  logic sw_lock;
  logic pwr_ok;

  fwp_strobe_filter #(.MIN_PULSE_CYC(MIN_PULSE_CYC)) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_ni (we_ni),
    .oe_ni (oe_ni),
    .stb_o (wr_stb_o)
  );

  fwp_por_timer #(.POR_CYC(POR_CYC)) u_por (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pwr_good_i(pwr_good_i),
    .done_o    (por_done)
  );

  fwp_lock_reg u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pwr_good_i(pwr_good_i),
    .set_i     (sw_lock_i),
    .lock_o    (sw_lock)
  );

  assign pwr_ok = pwr_good_i && por_done;

  fwp_prot_arbiter #(.ADDR_W(ADDR_W), .BOOT_BYTES(BOOT_BYTES)) u_arb (
    .addr_i   (addr_i),
    .pwr_ok_i (pwr_ok),
    .wp_ni    (wp_ni),
    .tbl_ni   (tbl_ni),
    .sw_lock_i(sw_lock),
    .allow_o  (allow_o)
  );

  a_r5_wp_blocks_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wp_ni |-> !allow_o);

  a_r4_pin_blocks_boot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tbl_ni && (addr_i >= BOOT_BASE)) |-> !allow_o);

  a_r9_power_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_good_i || !por_done) |-> !allow_o);

  a_r2_lock_blocks_boot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_lock && (addr_i >= BOOT_BASE)) |-> !allow_o);

endmodule

// File: tb/tb_fwp_top.sv
module tb_fwp_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 18;
  localparam int MIN = 3;
  localparam int POR = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          we_n = 1'b1, oe_n = 1'b1, tbl_n = 1'b1, wp_n = 1'b1;
  logic          pg = 1'b1, sw = 1'b0;
  logic          allow, stb;

  int  n_chk = 0, n_fail = 0;
  int  por_m = 0, q_m = 0;
  bit  lock_m = 0, stb_m = 0;
  bit  done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fwp_top #(.ADDR_W(AW), .BOOT_BYTES(16384), .MIN_PULSE_CYC(MIN), .POR_CYC(POR)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_ni(we_n), .oe_ni(oe_n),
    .tbl_ni(tbl_n), .wp_ni(wp_n), .pwr_good_i(pg), .sw_lock_i(sw),
    .allow_o(allow), .wr_stb_o(stb)
  );

  function automatic bit f_allow(logic [AW-1:0] a);
    bit boot = (a >= 18'h3C000);
    return pg && (por_m >= POR) && wp_n && !(boot && (!tbl_n || lock_m));
  endfunction

  // Advance the model by one edge using the inputs held now.
  task automatic tick();
    if (!rst_n) begin
      por_m = 0; q_m = 0; lock_m = 0; stb_m = 0;
    end else begin
      if (!pg) begin
        lock_m = 0; por_m = 0;
      end else begin
        if (sw) lock_m = 1;
        if (por_m < POR) por_m++;
      end
      if (!we_n && oe_n) begin
        if (q_m < MIN) q_m++;
        stb_m = (q_m >= MIN);
      end else begin
        q_m = 0; stb_m = 0;
      end
    end
    @(posedge clk);
    #1;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic chk_val(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic chk_model(string tag);
    n_chk++;
    if (allow !== f_allow(addr) || stb !== stb_m) begin
      n_fail++;
      $display("FAIL %s addr=%h actual allow=%b stb=%b expected allow=%b stb=%b",
               tag, addr, allow, stb, f_allow(addr), stb_m);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    r = $urandom(32'd20240611);

    // R11 reset state
    ticks(3);
    chk_val("R11 allow in reset", allow, 1'b0);
    chk_val("R11 stb in reset", stb, 1'b0);
    rst_n = 1'b1;

    // R9 power-on delay
    ticks(POR - 1);
    chk_val("R9 allow before delay ends", allow, 1'b0);
    tick();
    chk_val("R9 allow after delay", allow, 1'b1);

    // R1 boundaries with no protection
    addr = 18'h3FFFF; #1; chk_val("R1 top addr open", allow, 1'b1);
    addr = 18'h00000; #1; chk_val("R1 bottom addr open", allow, 1'b1);

    // R6 same-cycle address response
    tbl_n = 1'b0; #1;
    addr = 18'h3C000; #1; chk_val("R6 comb block", allow, 1'b0);
    addr = 18'h3BFFF; #1; chk_val("R6 comb open", allow, 1'b1);

    // R4 boot pin
    tick();
    chk_val("R4 below boot open", allow, 1'b1);
    addr = 18'h3FFFF; #1; chk_val("R4 boot blocked", allow, 1'b0);
    tbl_n = 1'b1; #1; chk_val("R4 released", allow, 1'b1);

    // R5 chip protect
    wp_n = 1'b0; addr = 18'h00010; #1; chk_val("R5 low addr blocked", allow, 1'b0);
    tbl_n = 1'b0; addr = 18'h3C000; #1; chk_val("R5 with tbl", allow, 1'b0);
    wp_n = 1'b1; tbl_n = 1'b1; #1;

    // R2 software lock
    sw = 1'b1; tick(); sw = 1'b0;
    addr = 18'h3C000; #1; chk_val("R2 boot base locked", allow, 1'b0);
    addr = 18'h3FFFF; #1; chk_val("R2 boot top locked", allow, 1'b0);
    addr = 18'h3BFFF; #1; chk_val("R2 below boot open", allow, 1'b1);

    // R3 sticky lock: more pulses and a strobe
    sw = 1'b1; tick(); sw = 1'b0;
    we_n = 1'b0; ticks(5); we_n = 1'b1; ticks(2);
    addr = 18'h3D000; #1; chk_val("R3 lock held", allow, 1'b0);
    chk_model("R3 model");

    // R7 short pulse rejected
    we_n = 1'b0;
    for (int i = 0; i < MIN - 1; i++) begin
      tick(); chk_val("R7 short pulse", stb, 1'b0);
    end
    we_n = 1'b1; tick(); chk_val("R7 short pulse end", stb, 1'b0);

    // R7 long pulse
    we_n = 1'b0;
    ticks(MIN - 1); chk_val("R7 before min", stb, 1'b0);
    tick(); chk_val("R7 at min", stb, 1'b1);
    ticks(3); chk_val("R7 held", stb, 1'b1);
    we_n = 1'b1; tick(); chk_val("R7 drop", stb, 1'b0);

    // R8 output enable inhibits and restarts count
    we_n = 1'b0; ticks(MIN); chk_val("R8 pre", stb, 1'b1);
    oe_n = 1'b0; tick(); chk_val("R8 oe inhibit", stb, 1'b0);
    oe_n = 1'b1; ticks(MIN - 1); chk_val("R8 restart", stb, 1'b0);
    tick(); chk_val("R8 restart done", stb, 1'b1);
    we_n = 1'b1; tick();

    // R10 power loss
    addr = 18'h00100;
    pg = 1'b0; #1; chk_val("R9 comb power block", allow, 1'b0);
    tick(); pg = 1'b1;
    ticks(POR - 1); chk_val("R10 delay restarted", allow, 1'b0);
    tick(); chk_val("R10 delay done", allow, 1'b1);
    addr = 18'h3FFFF; #1; chk_val("R10 lock cleared", allow, 1'b1);

    // Random mix (R1 R4 R5 R7 R8 R9)
    for (int c = 0; c < 600; c++) begin
      r = $urandom();
      if (r[1:0] == 0) we_n = ~we_n;
      oe_n = (r[5:3] != 0);
      sw   = (r[10:6] == 0);
      if (pg) pg = (r[16:11] != 0); else pg = (r[18:17] == 0);
      wp_n = (r[21:19] != 0);
      tbl_n = (r[23:22] != 0);
      addr = r[24] ? (18'h3C000 + 18'($signed({1'b0, r[30:25]}) - 32)) : 18'($urandom());
      #1;
      chk_model("R1/R5/R9 random comb");
      tick();
      chk_model("R7/R8 random after edge");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule